// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Interface

This block collects up to 32 interrupt sources and presents one interrupt request line to a processor. Each source can be raised by a hardware input or by a software-settable bit. A per-source enable mask gates it, and a fixed priority picks among the pending sources: source 0 is the most urgent. Each source has a programmable 32-bit vector address. A single-cycle register port exposes all of this state. Every transfer carries a privilege qualifier bit.

The service handshake runs through one register at offset 0xF00. The interrupt handler reads it to fetch the vector of the winning source, and that read also marks the source as in service. A write of any value to the same register ends service of the most urgent in-service source. A more urgent source may pre-empt one already in service, so several sources can be in service at once. A protection bit restricts every register to privileged transfers, and the protection register itself is always privileged-only.

The service tracker is a two-state machine. SVC_IDLE means no source is in service. SVC_BUSY means at least one source is in service. The transition IDLE→BUSY fires on an acknowledging read. The transition BUSY→IDLE fires on an end-of-service write when exactly one source is in service. In every other case the machine stays in its current state.

Top module: `vic_regif`

## Requirements
- R1: After reset the enable mask, software bits, protection bit, in-service set and held vector (0x00000000) are all zero, and `irq_o` is low.
- R2: A write to 0x010 sets the enable bits where the data holds 1s. A write to 0x014 clears the enable bits where the data holds 1s. A read of 0x010 returns the mask, and a read of 0x014 returns 0.
- R3: A write to 0x018 ORs the data into the software bits, and a read of 0x018 returns them. A source is raw-active when its `src_i` bit or its software bit is 1.
- R4: A write to 0x01C clears the software bits where the data holds 1s and leaves the bits where it holds 0s. A read of 0x01C returns 0.
- R5: The protection bit is bit 0 at offset 0x020. A read returns bits [31:1] as 0. The register is reached only when `bus_priv`=1, whatever the protection bit: a user access reads 0 and changes nothing.
- R6: With the protection bit at 1, a transfer with `bus_priv`=0 to any register reads 0 and changes no state. With the bit at 0, user transfers reach every register except 0x020.
- R7: The vector for source n is read and written at 0x100+4n.
- R8: `irq_o` is high exactly when some source that is both raw-active and enabled has a lower index than the lowest-indexed in-service source, or when such a source exists and none is in service.
- R9: A read of 0xF00 while `irq_o` is high returns the vector of the lowest-indexed active enabled source. The same read marks that source in service and loads that vector into the held value.
- R10: A read of 0xF00 while `irq_o` is low returns the held value and changes neither the held value nor the in-service set.
- R11: A write of any value to 0xF00 removes the lowest-indexed source from the in-service set and leaves the held value unchanged.
- R12: A read of 0xF00 that protection blocks does not acknowledge: it returns 0 and no source enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Hardware interrupt sources, one bit per source |
| bus_sel | input | 1 | Transfer valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | 1 = privileged transfer |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Assertions check four things on every cycle. A blocked transfer freezes the enable, software, protection and held-vector state. An acknowledge loads the returned vector and marks its source in service. An end-of-service write drops the most urgent in-service source. The state machine sits in SVC_IDLE only while nothing is in service. Other properties need a reference model and ordered stimulus, so only the bench scenarios can show them. These are the nesting order of pre-emption, the suppression of `irq_o` by an in-service source of equal or higher urgency, and the held value returned by a spurious acknowledge. They also include the privileged-only rule on the protection register while protection is off.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned OFF_ENA_SET = 'h010;
    localparam int unsigned OFF_ENA_CLR = 'h014;
    localparam int unsigned OFF_SWI_SET = 'h018;
    localparam int unsigned OFF_SWI_CLR = 'h01C;
    localparam int unsigned OFF_PROT    = 'h020;
    localparam int unsigned OFF_TBL     = 'h100;
    localparam int unsigned OFF_VECT    = 'hF00;

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_BUSY = 1'b1
    } svc_state_t;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // lowest set index wins: scanning downward, the last hit is kept
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vic_svc_ctrl.sv
module vic_svc_ctrl
    import vic_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack,
    input  logic [IW-1:0] ack_idx,
    input  logic          eoi,
    output logic          svc_vld,
    output logic [IW-1:0] svc_idx
);
    svc_state_t    state_q, state_d;
    logic [N-1:0]  insvc_q;
    logic          last_one;

    vic_prio_enc #(.N(N), .IW(IW)) u_svc_enc (
        .req   (insvc_q),
        .valid (svc_vld),
        .idx   (svc_idx)
    );

    assign last_one = (insvc_q & (insvc_q - N'(1))) == '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE: if (ack) state_d = SVC_BUSY;
            SVC_BUSY: if (eoi && last_one && !ack) state_d = SVC_IDLE;
            default:  state_d = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insvc_q <= '0;
        end else if (ack) begin
            insvc_q[ack_idx] <= 1'b1;
        end else if (eoi && svc_vld) begin
            insvc_q[svc_idx] <= 1'b0;
        end
    end

    AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> insvc_q[$past(ack_idx)]);                                   // R9
    AST_EOI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && svc_vld) |=> !insvc_q[$past(svc_idx)]);                     // R11
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SVC_IDLE) |-> (insvc_q == '0));                         // R11
endmodule

// File: rtl/vic_regif.sv
module vic_regif
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DW      = 32,
    parameter int AW      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_priv,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq_o
);
    localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int WA = AW - 2;
    localparam logic [WA-1:0] W_TBL = WA'(OFF_TBL >> 2);

    logic [NUM_SRC-1:0] ena_q, swi_q, pend;
    logic               prot_q;
    logic [DW-1:0]      vect_q;
    logic [DW-1:0]      vtab [NUM_SRC];

    logic [WA-1:0] waddr;
    logic          unused_lo;
    logic          hit_ena_set, hit_ena_clr, hit_swi_set, hit_swi_clr;
    logic          hit_prot, hit_vect, hit_tbl;
    logic [IW-1:0] tbl_idx;
    logic          allow, rd, wr, ack, eoi;
    logic          pend_vld, svc_vld;
    logic [IW-1:0] pend_idx, svc_idx;

    assign waddr       = bus_addr[AW-1:2];
    assign unused_lo   = ^bus_addr[1:0];
    assign hit_ena_set = waddr == WA'(OFF_ENA_SET >> 2);
    assign hit_ena_clr = waddr == WA'(OFF_ENA_CLR >> 2);
    assign hit_swi_set = waddr == WA'(OFF_SWI_SET >> 2);
    assign hit_swi_clr = waddr == WA'(OFF_SWI_CLR >> 2);
    assign hit_prot    = waddr == WA'(OFF_PROT >> 2);
    assign hit_vect    = waddr == WA'(OFF_VECT >> 2);
    assign hit_tbl     = (waddr >= W_TBL) && (waddr < W_TBL + WA'(NUM_SRC));
    assign tbl_idx     = IW'(waddr - W_TBL);

    // privilege gate: protection register always privileged, others only when protected
    assign allow = bus_sel && (bus_priv || (!prot_q && !hit_prot));
    assign rd    = allow && !bus_wr;
    assign wr    = allow && bus_wr;

    assign pend = (src_i | swi_q) & ena_q;

    vic_prio_enc #(.N(NUM_SRC), .IW(IW)) u_pend_enc (
        .req   (pend),
        .valid (pend_vld),
        .idx   (pend_idx)
    );

    vic_svc_ctrl #(.N(NUM_SRC), .IW(IW)) u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ack),
        .ack_idx (pend_idx),
        .eoi     (eoi),
        .svc_vld (svc_vld),
        .svc_idx (svc_idx)
    );

    assign irq_o = pend_vld && (!svc_vld || (pend_idx < svc_idx));
    assign ack   = rd && hit_vect && irq_o;
    assign eoi   = wr && hit_vect;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q  <= '0;
            swi_q  <= '0;
            prot_q <= 1'b0;
            vect_q <= '0;
        end else begin
            if (wr && hit_ena_set) ena_q  <= ena_q | bus_wdata[NUM_SRC-1:0];
            if (wr && hit_ena_clr) ena_q  <= ena_q & ~bus_wdata[NUM_SRC-1:0];
            if (wr && hit_swi_set) swi_q  <= swi_q | bus_wdata[NUM_SRC-1:0];
            if (wr && hit_swi_clr) swi_q  <= swi_q & ~bus_wdata[NUM_SRC-1:0];
            if (wr && hit_prot)    prot_q <= bus_wdata[0];
            if (ack)               vect_q <= vtab[pend_idx];
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_vtab
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                     vtab[g] <= '0;
            else if (wr && hit_tbl && tbl_idx == IW'(g))    vtab[g] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (hit_ena_set)      bus_rdata[NUM_SRC-1:0] = ena_q;
            else if (hit_swi_set) bus_rdata[NUM_SRC-1:0] = swi_q;
            else if (hit_prot)    bus_rdata[0] = prot_q;
            else if (hit_vect)    bus_rdata = irq_o ? vtab[pend_idx] : vect_q;
            else if (hit_tbl)     bus_rdata = vtab[tbl_idx];
        end
    end

    AST_BLOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !allow) |=> ($stable(ena_q) && $stable(swi_q) && $stable(prot_q) && $stable(vect_q))); // R6
    AST_BLOCKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !allow) |-> (!ack && bus_rdata == '0));                 // R12
    AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (vect_q == $past(bus_rdata)));                              // R9
    AST_VECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(vect_q));                                          // R10
    AST_SWI_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_swi_clr) |=> ((swi_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R4
endmodule

// File: tb/vic_regif_test.sv
module vic_regif_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_vec = 0, n_bad = 0, cyc = 0;

    logic [31:0] m_en, m_sw, m_vect, m_svc;
    logic        m_prot;
    logic [31:0] m_tab [32];

    vic_regif uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic int top_idx(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return i;
        return 32;
    endfunction

    function automatic bit m_irq();
        int p = top_idx((src_i | m_sw) & m_en);
        int s = top_idx(m_svc);
        return (p < 32) && (p < s);
    endfunction

    function automatic bit m_allow(input logic [11:0] a, input bit pv);
        return pv || (!m_prot && a[11:2] != 10'h008);
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a, input bit pv);
        if (!m_allow(a, pv)) return 32'h0;
        case (a[11:2])
            10'h004: return m_en;
            10'h006: return m_sw;
            10'h008: return {31'h0, m_prot};
            10'h3C0: return m_irq() ? m_tab[top_idx((src_i | m_sw) & m_en)] : m_vect;
            default: begin
                if (a[11:2] >= 10'h040 && a[11:2] < 10'h060) return m_tab[a[6:2]];
                return 32'h0;
            end
        endcase
    endfunction

    function automatic void m_apply(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit pv);
        int p;
        if (!m_allow(a, pv)) return;
        if (wr) begin
            case (a[11:2])
                10'h004: m_en = m_en | d;
                10'h005: m_en = m_en & ~d;
                10'h006: m_sw = m_sw | d;
                10'h007: m_sw = m_sw & ~d;
                10'h008: m_prot = d[0];
                10'h3C0: if (m_svc != 0) m_svc[top_idx(m_svc)] = 1'b0;
                default: if (a[11:2] >= 10'h040 && a[11:2] < 10'h060) m_tab[a[6:2]] = d;
            endcase
        end else if (a[11:2] == 10'h3C0 && m_irq()) begin
            p = top_idx((src_i | m_sw) & m_en);
            m_vect = m_tab[p];
            m_svc[p] = 1'b1;
        end
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit pv, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_priv = pv;
        #2;
        check({tag, " irq"}, {31'h0, irq_o}, {31'h0, m_irq()});
        if (!wr) check({tag, " rdata"}, bus_rdata, m_read(a, pv));
        @(posedge clk);
        m_apply(wr, a, d, pv);
        #1 bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input bit pv, input string tag);
        bus(1'b0, a, 32'h0, pv, tag);
    endtask

    task automatic wrt(input logic [11:0] a, input logic [31:0] d, input bit pv, input string tag);
        bus(1'b1, a, d, pv, tag);
    endtask

    initial begin
        void'($urandom(32'd2718));
        m_en = 0; m_sw = 0; m_vect = 0; m_svc = 0; m_prot = 0;
        for (int i = 0; i < 32; i++) m_tab[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h010, 1, "R1"); rd(12'h018, 1, "R1"); rd(12'h020, 1, "R1"); rd(12'hF00, 1, "R1");
        // R7 vector table
        for (int i = 0; i < 32; i++) wrt(12'h100 + 12'(4 * i), 32'h8000_0000 + 32'(i * 16), 1, "R7");
        rd(12'h100, 1, "R7"); rd(12'h17C, 1, "R7"); rd(12'h140, 0, "R7");
        // R2 enable set / clear
        wrt(12'h010, 32'h0000_00F0, 1, "R2"); wrt(12'h014, 32'h0000_0030, 1, "R2");
        rd(12'h010, 1, "R2"); rd(12'h014, 1, "R2");
        wrt(12'h010, 32'hFFFF_FFFF, 1, "R2");
        // R3 / R4 software bits
        wrt(12'h018, 32'h0000_0003, 1, "R3"); rd(12'h018, 1, "R3");
        wrt(12'h01C, 32'h0, 1, "R4"); rd(12'h018, 1, "R4");
        wrt(12'h01C, 32'h1, 1, "R4"); rd(12'h018, 1, "R4"); rd(12'h01C, 1, "R4");
        rd(12'hF00, 1, "R3");                      // acks software source 1
        wrt(12'hF00, 32'h0, 1, "R11");
        wrt(12'h01C, 32'hFFFF_FFFF, 1, "R4");
        // R8 / R9 / R11 nesting
        src_i = 32'h0010_0000;
        rd(12'h010, 1, "R8");
        rd(12'hF00, 1, "R9"); rd(12'h010, 1, "R8");
        src_i = 32'h0010_0020;
        rd(12'hF00, 1, "R9");
        src_i = 32'h0010_0420;
        rd(12'h010, 1, "R8");
        wrt(12'hF00, 32'hDEAD_BEEF, 1, "R11"); rd(12'hF00, 1, "R11");
        wrt(12'hF00, 32'h0, 1, "R11"); wrt(12'hF00, 32'h0, 1, "R11");
        src_i = 32'h0;
        wrt(12'hF00, 32'h0, 1, "R11");
        rd(12'hF00, 1, "R10"); rd(12'h010, 1, "R10");
        // R5 protection register privileged-only
        wrt(12'h020, 32'h1, 0, "R5"); rd(12'h020, 1, "R5"); rd(12'h020, 0, "R5");
        wrt(12'h018, 32'h0000_0100, 0, "R6"); rd(12'h018, 1, "R6");
        wrt(12'h020, 32'hFFFF_FFFF, 1, "R5"); rd(12'h020, 1, "R5");
        // R6 / R12 protection on
        rd(12'h010, 0, "R6"); wrt(12'h014, 32'hFFFF_FFFF, 0, "R6"); rd(12'h010, 1, "R6");
        rd(12'hF00, 0, "R12"); rd(12'h010, 1, "R12");
        rd(12'hF00, 1, "R12"); wrt(12'hF00, 32'h0, 1, "R12");
        wrt(12'h01C, 32'hFFFF_FFFF, 1, "R4");
        wrt(12'h020, 32'h0, 1, "R5");

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] d;
            logic [11:0] a;
            bit pv;
            int op;
            if ($urandom_range(0, 15) == 0) src_i = $urandom & $urandom & $urandom;
            op = $urandom_range(0, 11);
            pv = ($urandom_range(0, 7) != 0);
            d  = $urandom & $urandom;
            case (op)
                0: a = 12'h010;  1: a = 12'h014;  2: a = 12'h018;  3: a = 12'h01C;
                4: begin a = 12'h020; d = {31'h0, ($urandom_range(0, 3) == 0)}; end
                5: a = 12'h100 + 12'($urandom_range(0, 31) * 4);
                6, 7, 8: a = 12'hF00;
                9: a = 12'h004;
                default: a = 12'hF00;
            endcase
            bus(($urandom_range(0, 2) == 0) && op != 6 && op != 7, a, d, pv, "RND");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule